// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage shift register. It can either copy a parallel word into every stage or move its contents one position toward the last stage, taking a fresh bit from a serial input. The last stage drives two outputs, a true one and an inverted one. This lets a parallel word be streamed out one bit at a time, most significant stage first.

Everything runs on one fast system clock. The two shift-clock inputs are ordinary synchronous signals that are sampled each cycle. Their OR forms a combined clock, and its rising edge is detected against the value registered in the previous cycle. Because the two inputs are ORed, either one held high works as an inhibit for the other. If the inhibiting input rises while the other is low, the register shifts once, exactly as it would for a clock edge. The active-low load input is level-sensitive and takes priority over shifting.

Top module: `plso_shift_reg`

## Requirements
- R1: A synchronous active-high reset clears every stage, also when load is active. After reset, the combined clock counts as previously high, so a clock input that is already high when reset ends causes no shift.
- R2: While `load_n` is 0, every system clock edge copies `par_in[i]` into stage i, whatever the clock inputs do. A change of `par_in` during a long load therefore reaches the stages.
- R3: With `load_n` at 1, a cycle in which `clk_a | clk_b` is 1 and was 0 in the previous cycle moves the register one place. Stage 0 takes `ser_in` and stage i takes the old stage i-1, so the result is visible after that system clock edge.
- R4: With `load_n` at 1, the stages keep their value while the combined clock stays high, and also while it is low.
- R5: `clk_a` and `clk_b` are interchangeable. Either one held high blocks shifts from the other, including when the other one falls.
- R6: If one input rises while the other is low, that rise counts as a combined-clock edge and shifts once, even when the rising input was meant as an inhibit.
- R7: The previous combined-clock value keeps updating during a load. When load ends with the combined clock already high, no shift happens until the next 0-to-1 transition. When load ends in the same cycle that the combined clock rises, one shift happens.
- R8: `q_last` is stage 7 and `q_last_n` is always its complement.
- R9: After a parallel load, successive shifts present stages 7, 6, … 0 on `q_last` in that order. After eight shifts with `ser_in` at 0, `q_last` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load, active low, level-sensitive |
| clk_a | input | 1 | Shift-clock input A (ORed with B) |
| clk_b | input | 1 | Shift-clock input B (ORed with A) |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | W | Parallel word, bit i feeds stage i |
| q_last | output | 1 | Last stage, true |
| q_last_n | output | 1 | Last stage, inverted |

## Verification
The assertions assume that `clk_a`, `clk_b`, `ser_in`, `load_n` and `par_in` are synchronous to the system clock and are stable around its rising edge. An edge is then one sampled 0-to-1 step of the OR and never a glitch inside a cycle. The bench changes every input only on the falling system-clock edge and holds it for a full cycle. It shapes each shift-clock pulse as whole low and high cycles, so each rise of the combined clock is seen exactly once.

// File: rtl/plso_pkg.sv
package plso_pkg;

    localparam int DEF_STAGES = 8;

    // What the stage bank does on the next system clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SHIFT = 2'd2
    } stage_act_e;

    // Combined shift clock: value seen now and value seen one cycle earlier.
    typedef struct packed {
        logic level;
        logic prev;
    } clk_samp_t;

    // Load wins over everything; otherwise only a 0->1 step of the OR shifts.
    function automatic stage_act_e pick_act(input logic load_n, input clk_samp_t s);
        if (!load_n)
            return ACT_LOAD;
        if (s.level && !s.prev)
            return ACT_SHIFT;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/plso_clk_track.sv
module plso_clk_track
    import plso_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_n,
    input  logic       clk_a,
    input  logic       clk_b,
    output stage_act_e act
);

    logic      prev_q;
    clk_samp_t samp;

    always_comb begin
        samp.level = clk_a | clk_b;
        samp.prev  = prev_q;
    end

    // Keeps tracking during load; reset value 1 blocks a shift at reset release.
    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b1;
        else
            prev_q <= samp.level;
    end

    always_comb act = pick_act(load_n, samp);

endmodule

// File: rtl/plso_stage_bank.sv
module plso_stage_bank
    import plso_pkg::*;
#(
    parameter int W = DEF_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  stage_act_e   act,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] stage_q
);

    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic from_left;
        if (i == 0) begin : g_head
            assign from_left = ser_in;
        end else begin : g_body
            assign from_left = stage_q[i-1];
        end

        always_comb begin
            unique case (act)
                ACT_LOAD:  nxt[i] = par_in[i];
                ACT_SHIFT: nxt[i] = from_left;
                default:   nxt[i] = stage_q[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else
            stage_q <= nxt;
    end

endmodule

// File: rtl/plso_shift_reg.sv
module plso_shift_reg
    import plso_pkg::*;
#(
    parameter int W = DEF_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic         q_last,
    output logic         q_last_n
);

    localparam int LAST = W - 1;

    stage_act_e   act;
    logic [W-1:0] stage_q;

    plso_clk_track clk_track_i (
        .clk    (clk),
        .rst    (rst),
        .load_n (load_n),
        .clk_a  (clk_a),
        .clk_b  (clk_b),
        .act    (act)
    );

    plso_stage_bank #(.W(W)) stage_bank_i (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .ser_in  (ser_in),
        .par_in  (par_in),
        .stage_q (stage_q)
    );

    assign q_last   = stage_q[LAST];
    assign q_last_n = ~stage_q[LAST];

endmodule

// File: rtl/plso_checker.sv
module plso_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         load_n,
    input logic         clk_a,
    input logic         clk_b,
    input logic         ser_in,
    input logic [W-1:0] par_in,
    input logic [W-1:0] stage_q,
    input logic         q_last,
    input logic         q_last_n
);

    logic comb_now;
    logic comb_d;

    assign comb_now = clk_a | clk_b;

    always_ff @(posedge clk) begin
        if (rst)
            comb_d <= 1'b1;
        else
            comb_d <= comb_now;
    end

    // R2: a cycle with load active shows the parallel word after the edge
    assert_load_copies_R2: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> stage_q == $past(par_in));

    // R3 / R6: rising combined clock with load inactive shifts one place
    assert_shift_step_R3: assert property (@(posedge clk) disable iff (rst)
        (load_n && comb_now && !comb_d) |=>
            stage_q == {$past(stage_q[W-2:0]), $past(ser_in)});

    // R4 / R5: combined clock held high keeps contents
    assert_hold_high_R4: assert property (@(posedge clk) disable iff (rst)
        (load_n && comb_now && comb_d) |=> $stable(stage_q));

    // R4: combined clock low keeps contents
    assert_hold_low_R4: assert property (@(posedge clk) disable iff (rst)
        (load_n && !comb_now) |=> $stable(stage_q));

    // R8: outputs are complementary
    assert_complement_R8: assert property (@(posedge clk) disable iff (rst)
        q_last_n != q_last);

endmodule

bind plso_shift_reg plso_checker #(.W(W)) checker_i (
    .clk      (clk),
    .rst      (rst),
    .load_n   (load_n),
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .stage_q  (stage_q),
    .q_last   (q_last),
    .q_last_n (q_last_n)
);

// File: tb/plso_shift_reg_tb.sv
module plso_shift_reg_tb_top;

    localparam int W = 8;
    localparam int NV = 17;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_n = 1'b1;
    logic         clk_a = 1'b0;
    logic         clk_b = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         q_last;
    logic         q_last_n;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    plso_shift_reg #(.W(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .load_n   (load_n),
        .clk_a    (clk_a),
        .clk_b    (clk_b),
        .ser_in   (ser_in),
        .par_in   (par_in),
        .q_last   (q_last),
        .q_last_n (q_last_n)
    );

    // {load_n, clk_a, clk_b, ser_in, par_in[7:0], expected q_last}
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 1'b1}, // load while clock rises (R2)
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0}, // load follows new word (R2)
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0}, // clock low, hold (R4)
        {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0}, // A rises: 3C->79 (R3)
        {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // A held high (R4)
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}, // low
        {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1}, // B rises: 79->F2 (R5)
        {1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1}, // both high (R5)
        {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1}, // B falls, A inhibits (R5)
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1}, // low
        {1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1}, // inhibit rises alone: F2->E5 (R6)
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0}, // load 01
        {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // release with rise: 01->02 (R7)
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 1'b1}, // load 80, clock high
        {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1}, // release, clock already high (R7)
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1}, // low
        {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}  // real rise: 80->00 (R7)
    };

    task automatic apply(input logic l, input logic a, input logic b,
                         input logic s, input logic [W-1:0] p);
        @(negedge clk);
        load_n = l;
        clk_a  = a;
        clk_b  = b;
        ser_in = s;
        par_in = p;
        @(posedge clk);
        #5;
    endtask

    task automatic check(input logic exp, input string tag);
        checks++;
        if (q_last !== exp || q_last_n !== ~exp) begin
            failures++;
            $display("FAIL %s: q_last=%b q_last_n=%b expected %b/%b",
                     tag, q_last, q_last_n, exp, ~exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] word;

        // R1: reset state
        rst = 1'b1;
        apply(1'b1, 1'b0, 1'b0, 1'b0, '0);
        apply(1'b1, 1'b0, 1'b0, 1'b0, '0);
        check(1'b0, "R1 reset state");

        // Table walk
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:1]);
            check(VEC[i][0], $sformatf("table row %0d (R2 R3 R4 R5 R6 R7 R8)", i));
        end

        // R1: reset wins over an active load
        @(negedge clk);
        rst = 1'b1;
        apply(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
        check(1'b0, "R1 reset over load");

        // R1: clock already high when reset ends causes no shift
        apply(1'b1, 1'b1, 1'b0, 1'b1, '0);
        @(negedge clk);
        rst = 1'b0;
        apply(1'b1, 1'b1, 1'b0, 1'b1, '0);
        for (int k = 0; k < 7; k++) begin
            apply(1'b1, 1'b0, 1'b0, 1'b1, '0);
            apply(1'b1, 1'b1, 1'b0, 1'b1, '0);
        end
        check(1'b0, "R1 no shift at reset release (7 ones in)");
        apply(1'b1, 1'b0, 1'b0, 1'b1, '0);
        apply(1'b1, 1'b1, 1'b0, 1'b1, '0);
        check(1'b1, "R3 eighth shift reaches last stage");

        // R9: stream out a word through clk_b, then zeros beyond eight shifts
        word = 8'hB4;
        apply(1'b0, 1'b0, 1'b0, 1'b0, word);
        check(word[7], "R9 after load");
        for (int k = 1; k <= 12; k++) begin
            apply(1'b1, 1'b0, 1'b0, 1'b0, '0);
            apply(1'b1, 1'b0, 1'b1, 1'b0, '0);
            check((k < 8) ? word[7-k] : 1'b0, $sformatf("R9 shift %0d", k));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule